// File: doc/BRIEF.md
# Banded Gain Scaler

This block scales an unsigned sample by a gain that is picked from the value of the sample itself. Small values pass unchanged. Mid-range values are scaled by three quarters. Large values are scaled by five sixteenths. The product is formed from shifted copies of the sample and adders only, so no multiplier is needed. Four guard fraction bits keep the fractional part until the last step. That step either drops the fraction or rounds it half-up, depending on a per-sample mode bit.

Each accepted sample gives one registered result one clock later, marked by an output strobe. The result register keeps its value between strobes. Any input above the legal ceiling of 1000 is clamped to 1000 before it is scaled.

Top module: `pwg_scaler`

## Requirements
- R1: An input from 0 to 10 gives a result equal to the input (gain 1).
- R2: An input from 11 to 100 is scaled by 3/4.
- R3: An input from 101 to 1000 is scaled by 5/16. The result never exceeds 313.
- R4: When `in_round` is 0, the result is the scaled value with the fraction dropped, which is floor(v*num/den). For example, 1000 gives 312 and 14 gives 10.
- R5: When `in_round` is 1, the result is rounded half-up, which is floor((2*v*num+den)/(2*den)). An exact half rounds up: 14 gives 11, 104 gives 33 and 1000 gives 313.
- R6: An input from 1001 to 1023 gives the same result as an input of 1000 in the same mode.
- R7: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise.
- R8: A synchronous active-high `rst` clears `out_valid` and `out_data` to 0.
- R9: In a cycle after one with `in_valid` low, `out_data` keeps its previous value, whatever `in_data` and `in_round` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | IN_W (10) | Unsigned sample |
| in_round | input | 1 | 0 = truncate, 1 = round half-up |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | IN_W (10) | Scaled result |

## Verification
The bench targets the band edges 10/11 and 100/101. A wrong comparison at either edge would apply the neighbouring gain, so 11 would come out as 11 instead of 8, or 101 as 75 instead of 31.

It also drives the exact-half samples 14 and 104, where a rounding bias that is missing or has the wrong weight shows up as 10 or 32 in round mode. The clamp region 1001 to 1023 is driven too; a design without the clamp would return 5/16 of the raw value, for example 319 for 1023.

Gaps are placed in the sample stream with junk on the data pins. These catch a result register that loads without a strobe, and a strobe that arrives a cycle early, a cycle late, or not at all.

// File: rtl/pwg_pkg.sv
package pwg_pkg;

    typedef enum logic [1:0] {
        BAND_UNITY  = 2'd0,
        BAND_THREEQ = 2'd1,
        BAND_FIVE16 = 2'd2
    } band_e;

    typedef enum logic {
        RND_TRUNC   = 1'b0,
        RND_HALF_UP = 1'b1
    } rnd_e;

endpackage

// File: rtl/pwg_band_sel.sv
module pwg_band_sel
    import pwg_pkg::*;
#(
    parameter int IN_W       = 10,
    parameter int MAX_IN     = 1000,
    parameter int UNITY_TOP  = 10,
    parameter int THREEQ_TOP = 100
) (
    input  logic [IN_W-1:0] in_raw,
    output logic [IN_W-1:0] clamped,
    output band_e           band
);
    localparam logic [IN_W-1:0] CEIL  = IN_W'(MAX_IN);
    localparam logic [IN_W-1:0] LIM_U = IN_W'(UNITY_TOP);
    localparam logic [IN_W-1:0] LIM_T = IN_W'(THREEQ_TOP);

    always_comb begin
        clamped = (in_raw > CEIL) ? CEIL : in_raw;
        if (clamped <= LIM_U) begin
            band = BAND_UNITY;
        end else if (clamped <= LIM_T) begin
            band = BAND_THREEQ;
        end else begin
            band = BAND_FIVE16;
        end
    end
endmodule

// File: rtl/pwg_shift_add.sv
module pwg_shift_add
    import pwg_pkg::*;
#(
    parameter int IN_W   = 10,
    parameter int FRAC_W = 4
) (
    input  logic [IN_W-1:0]        x,
    input  band_e                  band,
    output logic [IN_W+FRAC_W-1:0] acc
);
    localparam int ACC_W = IN_W + FRAC_W;

    logic [ACC_W-1:0] ext;
    logic [ACC_W-1:0] term_unity;
    logic [ACC_W-1:0] term_threeq;
    logic [ACC_W-1:0] term_five16;

    always_comb begin
        ext         = ACC_W'(x);
        // gain 1: x scaled into the guard-bit frame
        term_unity  = ext << FRAC_W;
        // gain 3/4: (2x + x) * 2^FRAC_W / 4
        term_threeq = (ext << (FRAC_W - 1)) + (ext << (FRAC_W - 2));
        // gain 5/16: (4x + x) * 2^FRAC_W / 16
        term_five16 = (ext << (FRAC_W - 2)) + (ext << (FRAC_W - 4));
        unique case (band)
            BAND_UNITY:  acc = term_unity;
            BAND_THREEQ: acc = term_threeq;
            BAND_FIVE16: acc = term_five16;
            default:     acc = '0;
        endcase
    end
endmodule

// File: rtl/pwg_round.sv
module pwg_round
    import pwg_pkg::*;
#(
    parameter int ACC_W  = 14,
    parameter int FRAC_W = 4,
    parameter int OUT_W  = 10
) (
    input  logic [ACC_W-1:0] acc,
    input  rnd_e             mode,
    output logic [OUT_W-1:0] result
);
    localparam logic [ACC_W:0] HALF = (ACC_W+1)'(1) << (FRAC_W - 1);

    logic [ACC_W:0] biased;

    always_comb begin
        unique case (mode)
            RND_TRUNC:   biased = {1'b0, acc};
            RND_HALF_UP: biased = {1'b0, acc} + HALF;
            default:     biased = {1'b0, acc};
        endcase
        result = biased[FRAC_W +: OUT_W];
    end
endmodule

// File: rtl/pwg_scaler.sv
module pwg_scaler
    import pwg_pkg::*;
#(
    parameter int IN_W       = 10,
    parameter int FRAC_W     = 4,
    parameter int MAX_IN     = 1000,
    parameter int UNITY_TOP  = 10,
    parameter int THREEQ_TOP = 100
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [IN_W-1:0] in_data,
    input  logic            in_round,
    output logic            out_valid,
    output logic [IN_W-1:0] out_data
);
    localparam int ACC_W = IN_W + FRAC_W;

    logic [IN_W-1:0]  x_clamped;
    band_e            band;
    logic [ACC_W-1:0] acc;
    logic [IN_W-1:0]  scaled;
    rnd_e             mode;

    assign mode = rnd_e'(in_round);

    pwg_band_sel #(
        .IN_W(IN_W), .MAX_IN(MAX_IN),
        .UNITY_TOP(UNITY_TOP), .THREEQ_TOP(THREEQ_TOP)
    ) u_band (
        .in_raw(in_data), .clamped(x_clamped), .band(band)
    );

    pwg_shift_add #(.IN_W(IN_W), .FRAC_W(FRAC_W)) u_mul (
        .x(x_clamped), .band(band), .acc(acc)
    );

    pwg_round #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .OUT_W(IN_W)) u_rnd (
        .acc(acc), .mode(mode), .result(scaled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= scaled;
            end
        end
    end
endmodule

// File: rtl/pwg_scaler_chk.sv
module pwg_scaler_chk #(
    parameter int IN_W = 10
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [IN_W-1:0] in_data,
    input logic            out_valid,
    input logic [IN_W-1:0] out_data
);
    a_r7_strobe_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

    a_r1_unity_pass: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data <= IN_W'(10)) |=> (out_data == $past(in_data)));

    a_r3_ceiling: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data > IN_W'(100)) |=> (out_data <= IN_W'(313)));

    a_r8_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_data == '0));
endmodule

bind pwg_scaler pwg_scaler_chk #(.IN_W(IN_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
);

// File: tb/pwg_scaler_tb.sv
`timescale 1ns/1ps
module pwg_scaler_tb;
    localparam int IN_W = 10;

    typedef struct {
        int    val;
        string tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [IN_W-1:0] in_data = '0;
    logic            in_round = 1'b0;
    logic            out_valid;
    logic [IN_W-1:0] out_data;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   mon_on = 1'b0;
    int   last_out = 0;

    always #2.5 clk = ~clk;

    pwg_scaler u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_round(in_round), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ref_val(int v, bit rnd);
        int c, num, den;
        c = (v > 1000) ? 1000 : v;
        if (c <= 10) begin num = 1; den = 1; end
        else if (c <= 100) begin num = 3; den = 4; end
        else begin num = 5; den = 16; end
        return rnd ? (2*c*num + den) / (2*den) : (c*num) / den;
    endfunction

    function automatic string ref_tag(int v, bit rnd);
        string b;
        if (v > 1000) b = "R6";
        else if (v <= 10) b = "R1";
        else if (v <= 100) b = "R2";
        else b = "R3";
        return {b, rnd ? "/R5" : "/R4"};
    endfunction

    task automatic send(int v, bit rnd);
        exp_t e;
        in_valid = 1'b1;
        in_data  = IN_W'(v);
        in_round = rnd;
        e.val = ref_val(v, rnd);
        e.tag = ref_tag(v, rnd);
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(int junk);
        in_valid = 1'b0;
        in_data  = IN_W'(junk);
        in_round = junk[0];
        @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R7 strobe without sample", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(int'(out_data) == e.val, e.tag, int'(out_data), e.val);
                end
                last_out = int'(out_data);
            end else begin
                check(int'(out_data) == last_out, "R9 hold", int'(out_data), last_out);
            end
        end
    end

    initial begin
        #(200000 * 5);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) idle(0);
        rst = 1'b0;
        // R8: outputs cleared by reset
        check(out_valid == 1'b0, "R8 valid", int'(out_valid), 0);
        check(out_data == '0, "R8 data", int'(out_data), 0);
        mon_on = 1'b1;
        last_out = 0;
        // full sweep in both modes, with junk-filled gaps
        for (int rnd = 0; rnd < 2; rnd++) begin
            for (int v = 0; v < 1024; v++) begin
                send(v, rnd[0]);
                if (v % 7 == 6) idle(1023 - v);
            end
        end
        // explicit corners: half points and the band edges (R4, R5, R6)
        send(14, 1'b0); send(14, 1'b1);
        send(104, 1'b0); send(104, 1'b1);
        send(1000, 1'b0); send(1000, 1'b1);
        send(1023, 1'b1); send(10, 1'b1); send(11, 1'b0); send(101, 1'b1);
        repeat (3) idle(777);
        check(sb.size() == 0, "R7 missing strobes", sb.size(), 0);
        // reset while holding a nonzero result
        send(1000, 1'b1);
        idle(5);
        mon_on = 1'b0;
        rst = 1'b1;
        idle(9);
        idle(9);
        check(out_valid == 1'b0, "R8 valid after run", int'(out_valid), 0);
        check(out_data == '0, "R8 data after run", int'(out_data), 0);
        sb.delete();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule